// File: doc/BRIEF.md
# One-Time-Programmable Word Store with Mode Decoder

This block is a cycle-level, synthesizable model of the control logic of a x16 one-time-programmable memory. On each clock edge it samples two active-low strobes (chip select and output enable), a programming-supply flag and a flag that marks a high voltage on address line 9. It decodes these into one of seven operating modes, or an illegal combination. From the mode it drives the addressed word, drives an identification word, floats its outputs, or merges a program word into the backing array.

The tri-state data bus is represented by a data bus and a separate drive-enable. A location that has never been programmed reads as all ones. A program operation can only clear bits, because it ANDs the input word into the stored word. The array depth is a parameter. The block is a test target for a read controller and a programming sequencer. All outputs are registered, so the result of a cycle's inputs appears one clock later.

Top module: `otp_word_store`

## Requirements
- R1: After synchronous reset, `dout_en` and `err` are 0, and every location reads back as all ones.
- R2: With `ce_n`=0, `oe_n`=0, `vpp_hi`=0 and `hv_id`=0, the next cycle shows `dout_en`=1 and `dout` equal to the word stored at `addr`.
- R3: With `vpp_hi`=0 and either `ce_n`=1 (standby) or `oe_n`=1 (output off), the next cycle shows `dout_en`=0 and `err`=0, whatever the values of `hv_id` and `addr`.
- R4: With `ce_n`=0, `oe_n`=1 and `vpp_hi`=1, the word at `addr` becomes `stored & din` at that edge, and the next cycle shows `dout_en`=0.
- R5: A program operation never turns a stored 0 into a 1.
- R6: With `ce_n`=1, `oe_n`=0 and `vpp_hi`=1 (verify), the next cycle shows `dout_en`=1 and `dout` equal to the stored word at `addr`.
- R7: With `ce_n`=1, `oe_n`=1 and `vpp_hi`=1 (inhibit), the outputs float, `err` stays 0 and the array is unchanged.
- R8: With `ce_n`=0, `oe_n`=0, `vpp_hi`=0, `hv_id`=1 and `addr[AW-1:1]`=0, the next cycle shows `dout_en`=1. `dout` is 0x001E when `addr[0]`=0 and 0x00F4 when `addr[0]`=1.
- R9: Three input combinations are illegal: `hv_id`=1 together with `vpp_hi`=1; `ce_n`=0, `oe_n`=0 and `vpp_hi`=1; and the identification strobe combination with any of `addr[AW-1:1]` nonzero. For an illegal combination the next cycle shows `err`=1 and `dout_en`=0, and nothing is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| hv_id | input | 1 | High voltage present on address line 9 |
| vpp_hi | input | 1 | Programming supply present |
| addr | input | AW | Word address |
| din | input | DW | Program data |
| dout | output | DW | Data bus value |
| dout_en | output | 1 | Data bus is driven |
| err | output | 1 | Previous cycle held an illegal combination |

## Verification
On every cycle the assertions check the following. The bus is never driven in the cycle after a write. An error cycle never drives the bus. Standby and output-off never drive the bus. An identification request yields an upper byte of zero. A stored bit never rises across a write. Only the bench scenarios can show that stored contents are correct, that a merged value is correct after repeated programming, that inhibit and illegal cycles leave the array untouched, and that each identification word is correct. The bench shows these against a reference model, under random mode mixes and directed corner sequences.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_OUTOFF,
        MD_READ,
        MD_IDENT,
        MD_PROG,
        MD_VERIFY,
        MD_INHIBIT,
        MD_BAD
    } otp_mode_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic hv_id;
        logic vpp_hi;
    } otp_ctl_t;

    localparam int          ID_W     = 16;
    localparam logic [15:0] MFR_WORD = 16'h001E;
    localparam logic [15:0] DEV_WORD = 16'h00F4;

    function automatic logic [ID_W-1:0] id_word(input logic sel);
        return sel ? DEV_WORD : MFR_WORD;
    endfunction

    function automatic logic mode_drives_cell(input otp_mode_e m);
        return (m == MD_READ) || (m == MD_VERIFY);
    endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_pkg::*;
#(
    parameter int AW = 6
) (
    input  otp_ctl_t        ctl,
    input  logic [AW-1:0]   addr,
    output otp_mode_e       mode,
    output logic            wr_en
);

    logic upper_zero;

    always_comb begin
        upper_zero = (addr[AW-1:1] == '0);
        if (ctl.hv_id && ctl.vpp_hi) begin
            mode = MD_BAD;
        end else if (ctl.vpp_hi) begin
            unique case ({ctl.ce_n, ctl.oe_n})
                2'b00:   mode = MD_BAD;
                2'b01:   mode = MD_PROG;
                2'b10:   mode = MD_VERIFY;
                default: mode = MD_INHIBIT;
            endcase
        end else if (ctl.ce_n) begin
            mode = MD_STANDBY;
        end else if (ctl.oe_n) begin
            mode = MD_OUTOFF;
        end else if (ctl.hv_id) begin
            mode = upper_zero ? MD_IDENT : MD_BAD;
        end else begin
            mode = MD_READ;
        end
        wr_en = (mode == MD_PROG);
    end

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] rows [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                rows[i] <= '1;
            end
        end else if (wr_en) begin
            rows[addr] <= rows[addr] & wr_data;
        end
    end

    assign rd_data = rows[addr];

    // R5
    bits_only_clear_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((rows[$past(addr)] & ~$past(rd_data)) == '0));

endmodule

// File: rtl/otp_out_stage.sv
module otp_out_stage
    import otp_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  otp_mode_e     mode,
    input  logic [DW-1:0] cell_word,
    input  logic          id_sel,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic          err
);

    logic [DW-1:0] id_fit;

    generate
        if (DW >= ID_W) begin : g_id_wide
            assign id_fit = {{(DW-ID_W){1'b0}}, id_word(id_sel)};
        end else begin : g_id_narrow
            logic [ID_W-1:0] id_full;
            assign id_full = id_word(id_sel);
            assign id_fit  = id_full[DW-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            dout    <= '0;
            dout_en <= 1'b0;
            err     <= 1'b0;
        end else begin
            err <= (mode == MD_BAD);
            if (mode_drives_cell(mode)) begin
                dout    <= cell_word;
                dout_en <= 1'b1;
            end else if (mode == MD_IDENT) begin
                dout    <= id_fit;
                dout_en <= 1'b1;
            end else begin
                dout    <= '0;
                dout_en <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/otp_word_store.sv
module otp_word_store
    import otp_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          hv_id,
    input  logic          vpp_hi,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic          err
);

    otp_ctl_t      ctl;
    otp_mode_e     mode;
    logic          wr_en;
    logic [DW-1:0] cell_word;

    assign ctl = '{ce_n: ce_n, oe_n: oe_n, hv_id: hv_id, vpp_hi: vpp_hi};

    otp_mode_decode #(.AW(AW)) u_decode (
        .ctl   (ctl),
        .addr  (addr),
        .mode  (mode),
        .wr_en (wr_en)
    );

    otp_cell_array #(.AW(AW), .DW(DW)) u_array (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (din),
        .rd_data (cell_word)
    );

    otp_out_stage #(.DW(DW)) u_out (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .cell_word (cell_word),
        .id_sel    (addr[0]),
        .dout      (dout),
        .dout_en   (dout_en),
        .err       (err)
    );

    // R4
    no_drive_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !dout_en);

    // R9
    err_floats_bus_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> !dout_en);

    // R3
    idle_floats_chk: assert property (@(posedge clk) disable iff (rst)
        (!vpp_hi && (ce_n || oe_n)) |=> (!dout_en && !err));

    // R8
    ident_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (hv_id && !vpp_hi && !ce_n && !oe_n && (addr[AW-1:1] == '0))
            |=> (dout_en && (dout[DW-1:8] == '0)));

endmodule

// File: tb/otp_word_store_tb.sv
module otp_word_store_tb;

    localparam int AW    = 6;
    localparam int DW    = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1, oe_n = 1'b1, hv_id = 1'b0, vpp_hi = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din  = '0;
    logic [DW-1:0] dout;
    logic          dout_en, err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [DW-1:0] ref_mem [DEPTH];

    always #4 clk = ~clk;

    otp_word_store #(.AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .hv_id(hv_id),
        .vpp_hi(vpp_hi), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en), .err(err)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference: returns expected drive, error, data and write for one cycle.
    function automatic void model(input logic c, input logic o, input logic h, input logic v,
                                  input logic [AW-1:0] a, input logic [DW-1:0] d,
                                  output logic en, output logic er,
                                  output logic [DW-1:0] q, output logic wr);
        en = 0; er = 0; q = '0; wr = 0;
        if (h && v)                   er = 1;
        else if (v && !c && !o)       er = 1;
        else if (v && !c && o)        wr = 1;
        else if (v && c && !o)        begin en = 1; q = ref_mem[a]; end
        else if (v)                   ;
        else if (c || o)              ;
        else if (h && a[AW-1:1] != 0) er = 1;
        else if (h)                   begin en = 1; q = a[0] ? 16'h00F4 : 16'h001E; end
        else                          begin en = 1; q = ref_mem[a]; end
        if (wr) q = d;
    endfunction

    task automatic cycle(input logic c, input logic o, input logic h, input logic v,
                         input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
        logic en, er, wr;
        logic [DW-1:0] q;
        ce_n = c; oe_n = o; hv_id = h; vpp_hi = v; addr = a; din = d;
        model(c, o, h, v, a, d, en, er, q, wr);
        @(negedge clk);
        check({req, " drive"}, {15'd0, dout_en}, {15'd0, en});
        check({req, " err"},   {15'd0, err},     {15'd0, er});
        if (en) check({req, " data"}, dout, q);
        if (wr) ref_mem[a] = ref_mem[a] & d;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h0715_5EED));
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '1;
        @(negedge clk); @(negedge clk);
        rst = 0;
        check("R1 reset drive", {15'd0, dout_en}, 16'd0);
        check("R1 reset err",   {15'd0, err},     16'd0);
        for (int i = 0; i < DEPTH; i++) cycle(0, 0, 0, 0, AW'(i), '0, "R1 fresh ones");
        check("R1 ones model", ref_mem[3], 16'hFFFF);

        cycle(0, 1, 0, 1, 6'd5, 16'hA5F0, "R4 program");
        cycle(0, 0, 0, 0, 6'd5, '0, "R2 read back");
        check("R4 merged", ref_mem[5], 16'hA5F0);
        cycle(0, 1, 0, 1, 6'd5, 16'h0FFF, "R5 no raise");
        cycle(1, 0, 0, 1, 6'd5, '0, "R6 verify");
        check("R5 merged", ref_mem[5], 16'h05F0);

        cycle(1, 1, 0, 1, 6'd7, 16'h0000, "R7 inhibit");
        cycle(0, 0, 0, 0, 6'd7, '0, "R7 untouched");

        cycle(0, 0, 1, 0, 6'd0, '0, "R8 maker word");
        cycle(0, 0, 1, 0, 6'd1, '0, "R8 device word");
        cycle(0, 0, 1, 0, 6'd2, '0, "R9 upper bit set");
        cycle(0, 1, 1, 1, 6'd9, 16'h0000, "R9 hv with vpp");
        cycle(0, 0, 0, 0, 6'd9, '0, "R9 no write");
        cycle(0, 0, 0, 1, 6'd9, 16'h0000, "R9 both strobes with vpp");
        cycle(0, 0, 0, 0, 6'd9, '0, "R9 still unwritten");

        cycle(1, 0, 1, 0, 6'd0, '0, "R3 standby hv");
        cycle(0, 1, 0, 0, 6'd5, '0, "R3 output off");
        cycle(1, 1, 0, 0, 6'd1, '0, "R3 standby");

        for (int k = 0; k < 800; k++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            a = AW'($urandom);
            if ($urandom_range(0, 3) == 0) a = AW'($urandom_range(0, 1));
            d = DW'($urandom) | DW'($urandom);
            cycle(1'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0),
                  1'($urandom), a, d, "R2/R4/R6/R8/R9 random");
        end
        finish_run();
    end

endmodule